// File: doc/BRIEF.md
# Overload Auto-Restart Fault Controller

This block sequences overload protection for a switching power converter. Once per switching period a cycle tick arrives along with a flag that says whether the peak-current limit was hit during that period. A leaky-bucket fault integrator rises by one on every limited period and falls by one on every clean period. It saturates at zero. When the integrator reaches its trip count, the block pulls the switch enable low and holds it low for a fixed restart wait. It then releases switching through a soft-start interval and returns to normal running.

A persistent short keeps tripping, so the converter makes restart attempts at a low rate. A brief or sparse overload drains away without interrupting switching. The restart wait and the soft-start length are measured in clock ticks, not switching periods, because no periods occur while the switch is held off. Every input and output is synchronous to one clock. The reset is synchronous and active low.

Top module: `olp_restart_ctrl`

## Requirements
- R1: While reset is held and after it is released, switch_en is 1, ss_active is 0 and the fault integrator is empty.
- R2: Starting from an empty integrator, OVL_CYCLES consecutive ticks with ilim_hit=1 trip the block. switch_en goes to 0 in the clock after the edge that samples the OVL_CYCLES-th limited tick, and it stays 1 after only OVL_CYCLES-1 such ticks.
- R3: A tick with ilim_hit=0 lowers the integrator by one, but not below zero. Clean ticks on an empty integrator therefore do not shorten the next trip, which still takes exactly OVL_CYCLES limited ticks.
- R4: A pattern that alternates limited and clean ticks never trips.
- R5: Intermittent limits trip early by the net count held. After A limited ticks and then C clean ticks (C not above A), a further OVL_CYCLES-A+C limited ticks trip the block.
- R6: After a trip, switch_en stays 0 with ss_active=0 for exactly RESTART_TICKS clocks. Soft start then begins.
- R7: Cycle ticks and limit flags during the off wait are ignored. The integrator is cleared when the off wait is entered and when soft start begins.
- R8: Soft start drives switch_en=1 and ss_active=1. If it does not trip, it lasts exactly SS_TICKS clocks and is followed by normal running with ss_active=0.
- R9: Limited ticks during soft start are counted as they are in normal running. Reaching the trip count inside soft start enters the off wait at once, so a persistent overload repeats the trip, wait and soft-start sequence.
- R10: Clocks without cycle_tick leave the integrator unchanged, whatever ilim_hit shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cycle_tick | input | 1 | One-clock pulse marking the end of a switching period |
| ilim_hit | input | 1 | Peak-current limit seen in the period closed by cycle_tick |
| switch_en | output | 1 | Power switch allowed to run; low only during the off wait |
| ss_active | output | 1 | Soft-start interval in progress |

## Verification
The bench aims at the exact trip boundary. A design that trips one period early or late fails there, and so does one that lets stale clean ticks drive the integrator below zero and then needs extra limited ticks. It counts the length of the off wait and of soft start to the clock, which catches timers that are off by one. It also sends limited ticks during the off wait, which exposes a design that counts while the switch is off or that fails to clear the integrator at soft start. A persistent short that trips inside soft start checks that limits there are counted and that the cycle repeats. Alternating and intermittent patterns check that the integrator leaks rather than only accumulating.

// File: rtl/olp_pkg.sv
// Package olp_pkg
// Shared types for the overload auto-restart controller.
// Assumes: the state encoding is private to the block and never leaves it.
package olp_pkg;

    // Protection sequencer states
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,   // normal switching, integrator active
        ST_OFF  = 2'd1,   // switch held off, waiting for restart
        ST_SOFT = 2'd2    // soft-start interval, integrator active
    } olp_state_t;

endpackage

// File: rtl/olp_fault_integ.sv
// Module olp_fault_integ
// Leaky-bucket fault integrator. On each enabled cycle tick it counts up
// for a limited period and down for a clean one, saturating at zero. It
// flags a trip on the tick that would bring the count to OVL_CYCLES.
// Assumes: OVL_CYCLES >= 2. The caller clears the count on the same edge
// that a trip is taken, so the stored level never exceeds OVL_CYCLES-1.
module olp_fault_integ #(
    parameter int OVL_CYCLES = 16,
    parameter int CW         = $clog2(OVL_CYCLES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          count_en,
    input  logic          cycle_tick,
    input  logic          ilim_hit,
    input  logic          clear,
    output logic [CW-1:0] level,
    output logic          trip
);

    localparam logic [CW-1:0] LAST_BELOW = CW'(OVL_CYCLES - 1);

    logic tick_ok;

    // Qualify the tick with the sequencer's enable
    assign tick_ok = count_en && cycle_tick;

    // A limited tick at the top step completes the trip count
    assign trip = tick_ok && ilim_hit && (level == LAST_BELOW);

    // Up/down integration with clear priority and a floor at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (clear) begin
            level <= '0;
        end else if (tick_ok) begin
            if (ilim_hit) begin
                if (level != LAST_BELOW)
                    level <= level + 1'b1;
            end else if (level != '0) begin
                level <= level - 1'b1;
            end
        end
    end

endmodule

// File: rtl/olp_phase_timer.sv
// Module olp_phase_timer
// Down-counting clock-tick timer shared by the off wait and soft start.
// A load presets it to (interval - 1). It then counts one per clock while
// run is high, and expired is raised in the last clock of the interval.
// Assumes: load and run are never high together with a meaningless value.
module olp_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          run,
    output logic          expired
);

    logic [TW-1:0] remain;

    // The final clock of the interval is the one in which remain is zero
    assign expired = (remain == '0);

    // Preset on phase entry, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (run && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

endmodule

// File: rtl/olp_seq_fsm.sv
// Module olp_seq_fsm
// Protection sequencer. It moves RUN -> OFF on a trip, OFF -> SOFT when the
// restart wait expires, and SOFT -> RUN when soft start completes. A trip
// during SOFT returns it to OFF at once. On each entry to OFF or SOFT it
// loads the phase timer and clears the fault integrator.
// Assumes: RESTART_TICKS >= 1, SS_TICKS >= 1, both below 2**TW + 1.
module olp_seq_fsm
    import olp_pkg::*;
#(
    parameter int RESTART_TICKS = 120,
    parameter int SS_TICKS      = 40,
    parameter int TW            = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trip,
    input  logic          expired,
    output olp_state_t    state,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          tmr_run,
    output logic          integ_clear,
    output logic          integ_en
);

    localparam logic [TW-1:0] OFF_PRESET  = TW'(RESTART_TICKS - 1);
    localparam logic [TW-1:0] SOFT_PRESET = TW'(SS_TICKS - 1);

    olp_state_t state_nx;
    logic       enter_off;
    logic       enter_soft;

    // Next-state selection; a trip outranks soft-start completion
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (trip) state_nx = ST_OFF;
            ST_OFF:  if (expired) state_nx = ST_SOFT;
            ST_SOFT: begin
                if (trip)         state_nx = ST_OFF;
                else if (expired) state_nx = ST_RUN;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // Phase-entry strobes
    assign enter_off  = (state != ST_OFF)  && (state_nx == ST_OFF);
    assign enter_soft = (state != ST_SOFT) && (state_nx == ST_SOFT);

    // Timer control: preset on entry, run while a timed phase is held
    assign tmr_load = enter_off || enter_soft;
    assign tmr_val  = enter_off ? OFF_PRESET : SOFT_PRESET;
    assign tmr_run  = (state == ST_OFF) || (state == ST_SOFT);

    // Integrator control: frozen while off, cleared at each phase entry
    assign integ_clear = tmr_load;
    assign integ_en    = (state != ST_OFF);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

endmodule

// File: rtl/olp_restart_ctrl.sv
// Module olp_restart_ctrl (top)
// Overload auto-restart controller. It integrates per-period current-limit
// flags, stops the power switch on a trip, waits RESTART_TICKS clocks and
// restarts through SS_TICKS clocks of soft start.
// Assumes: cycle_tick is a one-clock pulse and ilim_hit is valid with it.
// All inputs are synchronous to clk.
module olp_restart_ctrl
    import olp_pkg::*;
#(
    parameter int OVL_CYCLES    = 16,
    parameter int RESTART_TICKS = 120,
    parameter int SS_TICKS      = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cycle_tick,
    input  logic ilim_hit,
    output logic switch_en,
    output logic ss_active
);

    localparam int CW       = $clog2(OVL_CYCLES);
    localparam int MAX_TICK = (RESTART_TICKS > SS_TICKS) ? RESTART_TICKS : SS_TICKS;
    localparam int TW       = (MAX_TICK > 1) ? $clog2(MAX_TICK) : 1;

    olp_state_t    state;
    logic [CW-1:0] fault_level;
    logic          trip;
    logic          expired;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_run;
    logic          integ_clear;
    logic          integ_en;

    // Fault integrator
    olp_fault_integ #(
        .OVL_CYCLES (OVL_CYCLES),
        .CW         (CW)
    ) u_integ (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en   (integ_en),
        .cycle_tick (cycle_tick),
        .ilim_hit   (ilim_hit),
        .clear      (integ_clear),
        .level      (fault_level),
        .trip       (trip)
    );

    // Shared timer for the off wait and soft start
    olp_phase_timer #(
        .TW       (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .expired  (expired)
    );

    // Sequencer
    olp_seq_fsm #(
        .RESTART_TICKS (RESTART_TICKS),
        .SS_TICKS      (SS_TICKS),
        .TW            (TW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .trip        (trip),
        .expired     (expired),
        .state       (state),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .tmr_run     (tmr_run),
        .integ_clear (integ_clear),
        .integ_en    (integ_en)
    );

    // Output decode from the registered state
    assign switch_en = (state != ST_OFF);
    assign ss_active = (state == ST_SOFT);

endmodule

// File: rtl/olp_restart_chk.sv
// Module olp_restart_chk
// Assertion checker for olp_restart_ctrl, attached with bind. It measures
// the off and soft-start phases with its own counters and checks the
// integrator level as seen at the top.
// Assumes: it is bound to the top, with fault_level wired to the integrator.
module olp_restart_chk #(
    parameter int OVL_CYCLES    = 16,
    parameter int RESTART_TICKS = 120,
    parameter int SS_TICKS      = 40,
    parameter int CW            = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cycle_tick,
    input logic          ilim_hit,
    input logic          switch_en,
    input logic          ss_active,
    input logic [CW-1:0] fault_level
);

    int unsigned off_len;
    int unsigned ss_len;

    // Count the consecutive clocks spent in the off wait
    always_ff @(posedge clk) begin
        if (!rst_n)         off_len <= 0;
        else if (!switch_en) off_len <= off_len + 1;
        else                off_len <= 0;
    end

    // Count the consecutive clocks spent in soft start
    always_ff @(posedge clk) begin
        if (!rst_n)        ss_len <= 0;
        else if (ss_active) ss_len <= ss_len + 1;
        else               ss_len <= 0;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (switch_en && !ss_active && fault_level == '0));

    // R2
    run_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_en && !ss_active && cycle_tick && ilim_hit &&
         fault_level == CW'(OVL_CYCLES - 1)) |=> !switch_en);

    // R3
    floor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_en && !ss_active && cycle_tick && !ilim_hit &&
         fault_level == '0) |=> (fault_level == '0));

    // R6
    off_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(switch_en) |-> (ss_active && off_len == RESTART_TICKS));

    // R7
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !switch_en |-> (fault_level == '0 && !ss_active));

    // R8
    soft_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ss_active) && switch_en) |-> (ss_len == SS_TICKS));

    // R9
    soft_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_active && cycle_tick && ilim_hit &&
         fault_level == CW'(OVL_CYCLES - 1)) |=> (!switch_en && !ss_active));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_en && !ss_active && !cycle_tick) |=> $stable(fault_level));

endmodule

bind olp_restart_ctrl olp_restart_chk #(
    .OVL_CYCLES    (OVL_CYCLES),
    .RESTART_TICKS (RESTART_TICKS),
    .SS_TICKS      (SS_TICKS),
    .CW            (CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_tick  (cycle_tick),
    .ilim_hit    (ilim_hit),
    .switch_en   (switch_en),
    .ss_active   (ss_active),
    .fault_level (fault_level)
);

// File: tb/olp_restart_ctrl_test.sv
`timescale 1ns/1ps
// Self-checking bench for olp_restart_ctrl: directed corner cases plus
// seeded random traffic. A requirement-level model predicts the outputs.
module olp_restart_ctrl_test;

    localparam int OVL = 16;
    localparam int RST = 120;
    localparam int SST = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cycle_tick = 1'b0;
    logic ilim_hit = 1'b0;
    logic switch_en;
    logic ss_active;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // Model state: 0 run, 1 off, 2 soft start
    int m_phase = 0;
    int m_level = 0;
    int m_left  = 0;

    always #2.5 clk = ~clk;

    olp_restart_ctrl #(
        .OVL_CYCLES    (OVL),
        .RESTART_TICKS (RST),
        .SS_TICKS      (SST)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cycle_tick (cycle_tick),
        .ilim_hit   (ilim_hit),
        .switch_en  (switch_en),
        .ss_active  (ss_active)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected switch_en for the model phase
    function automatic bit exp_en(input int ph);
        return ph != 1;
    endfunction

    // Expected ss_active for the model phase
    function automatic bit exp_ss(input int ph);
        return ph == 2;
    endfunction

    // Advance the model by one clock with the driven inputs
    task automatic model_edge(input bit tk, input bit lm);
        if (m_phase == 1) begin
            m_left--;
            if (m_left == 0) begin m_phase = 2; m_level = 0; m_left = SST; end
        end else begin
            if (tk && lm && m_level == OVL - 1) begin
                m_phase = 1; m_level = 0; m_left = RST;
            end else begin
                if (tk && lm) m_level++;
                else if (tk && m_level > 0) m_level--;
                if (m_phase == 2) begin
                    m_left--;
                    if (m_left == 0) m_phase = 0;
                end
            end
        end
    endtask

    // One clock: drive at the falling edge, compare 1 ns after the rise
    task automatic step(input bit tk, input bit lm, input string tag);
        @(negedge clk);
        cycle_tick = tk;
        ilim_hit   = lm;
        @(posedge clk);
        model_edge(tk, lm);
        #1;
        chk(switch_en == exp_en(m_phase), {tag, " switch_en"}, switch_en, exp_en(m_phase));
        chk(ss_active == exp_ss(m_phase), {tag, " ss_active"}, ss_active, exp_ss(m_phase));
    endtask

    // Idle clocks until the model is back in normal running
    task automatic settle(input string tag);
        while (m_phase != 0) step(1'b0, 1'b0, tag);
    endtask

    // Watchdog: a hang counts as one failed check
    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hang expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int off_cnt;
        int ss_cnt;
        int trips;
        bit dropped;
        void'($urandom(32'd20240607));

        // R1: reset state
        repeat (4) @(posedge clk);
        #1;
        chk(switch_en == 1'b1, "R1 reset switch_en", switch_en, 1);
        chk(ss_active == 1'b0, "R1 reset ss_active", ss_active, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0, "R1");

        // R10 and R2: limit flag without ticks, then exact trip count
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, "R10");
        for (int i = 0; i < OVL - 1; i++) begin
            step(1'b1, 1'b1, "R2");
            step(1'b0, 1'b1, "R10");
        end
        chk(switch_en == 1'b1, "R2 before trip", switch_en, 1);
        step(1'b1, 1'b1, "R2");
        chk(switch_en == 1'b0, "R2 at trip", switch_en, 0);

        // R6 and R7: off length with limited ticks ignored
        off_cnt = 1;
        while (!switch_en && off_cnt < RST + 10) begin
            step(1'b1, 1'b1, "R7");
            if (!switch_en) off_cnt++;
        end
        chk(off_cnt == RST, "R6 off length", off_cnt, RST);
        chk(ss_active == 1'b1, "R8 soft start entered", ss_active, 1);

        // R8: untroubled soft start length
        ss_cnt = 1;
        while (ss_active && ss_cnt < SST + 10) begin
            step(1'b0, 1'b0, "R8");
            if (ss_active) ss_cnt++;
        end
        chk(ss_cnt == SST, "R8 soft length", ss_cnt, SST);

        // R3: clean ticks at zero do not bank credit
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, "R3");
        for (int i = 0; i < OVL - 1; i++) step(1'b1, 1'b1, "R3");
        chk(switch_en == 1'b1, "R3 before trip", switch_en, 1);
        step(1'b1, 1'b1, "R3");
        chk(switch_en == 1'b0, "R3 at trip", switch_en, 0);
        settle("R3");

        // R4: alternating pattern never trips
        dropped = 1'b0;
        for (int i = 0; i < 400; i++) begin
            step(1'b1, i[0], "R4");
            if (!switch_en) dropped = 1'b1;
        end
        chk(!dropped, "R4 alternating", dropped, 0);
        for (int i = 0; i < OVL; i++) step(1'b1, 1'b0, "R4");

        // R5: net count shortens the trip
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, "R5");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R5");
        for (int i = 0; i < OVL - 10 + 3 - 1; i++) step(1'b1, 1'b1, "R5");
        chk(switch_en == 1'b1, "R5 before trip", switch_en, 1);
        step(1'b1, 1'b1, "R5");
        chk(switch_en == 1'b0, "R5 at trip", switch_en, 0);
        settle("R5");

        // R9: persistent short trips inside soft start and repeats
        trips = 0;
        for (int i = 0; i < 3 * (OVL + RST + SST); i++) begin
            bit was_en;
            was_en = switch_en;
            step(1'b1, 1'b1, "R9");
            if (was_en && !switch_en) trips++;
        end
        chk(trips >= 3, "R9 repeated trips", trips, 3);
        settle("R9");

        // Random traffic with varying limit density
        for (int i = 0; i < 6000; i++) begin
            int dens;
            bit tk;
            bit lm;
            dens = (i / 1000) * 20;
            tk = ($urandom % 3) == 0;
            lm = ($urandom % 100) < dens;
            step(tk, lm, "R2 random");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule